// File: doc/BRIEF.md
# Output Line Register Bank with Open-Drain Control

This block is the register bank for one bank of general-purpose I/O lines, reached over a simple APB-style bus. It holds the output data for every line. Software can change the data in three ways: a set register forces bits to 1, a clear register forces bits to 0, and a direct data write changes only the bits that a separate write-permission mask allows. A second set of enable, disable and status registers puts individual lines into open-drain mode. In that mode a 0 pulls the pad low and a 1 releases it. Open-drain mode applies whether the line is driven by this bank or handed to a peripheral.

The level on each pad passes through a synchronizer and is then available as a read-only pin word. It reads the actual pad level whatever is driving the line. The pin word only updates while the controller clock enable is high, so it freezes when that clock is gated. Bus writes take effect at the end of the access phase. Reads are combinational while the select is high and write is low.

Top module: `gpio_odrv_bank`

## Requirements
- R1: A write to the set register (offset 0x00) forces to 1 every output data bit written as 1. Bits written as 0 keep their value, and output data changes only on a bus write.
- R2: A write to the clear register (offset 0x04) forces to 0 every output data bit written as 1. Bits written as 0 keep their value.
- R3: A write to the data register (offset 0x08) loads only the bits whose write-permission bit is 1, and all other bits keep their value. Reading offset 0x08 returns the output data.
- R4: The write-permission mask is set by writes to offset 0x0C and cleared by writes to offset 0x10, one bit per written 1. It reads back at offset 0x14 and is all zeros after reset.
- R5: The open-drain mask is set by writes to offset 0x18 and cleared by writes to offset 0x1C. It reads back at offset 0x20 and is all zeros after reset.
- R6: On an open-drain line whose source output enable is 1, a data value of 0 drives the pad low (pad_oe=1, pad_out=0) and a value of 1 releases it (pad_oe=0). On a line that is not open-drain, pad_out equals the data and pad_oe equals the source output enable.
- R7: A line with periph_sel=1 takes its data and enable from periph_out and periph_oe instead of the bank, and open-drain mode applies to it in the same way.
- R8: The pin word at offset 0x24 returns the pad_in level of every line, whether the line is an input, driven by the bank or driven by a peripheral. A change made by a write is visible there two clock cycles after the write edge.
- R9: While clk_en is 0 the pin word holds the value it had when clk_en fell. It follows the pads again once clk_en returns to 1.
- R10: After reset the output data is all zeros, so every push-pull line that has its output enable set drives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | LINES | Write data |
| prdata | output | LINES | Read data, combinational while psel=1 and pwrite=0 |
| clk_en | input | 1 | Controller clock enable; gates the pin-word update |
| out_en | input | LINES | Output enable per line when the bank drives it |
| periph_sel | input | LINES | 1 hands the line to a peripheral |
| periph_out | input | LINES | Peripheral data per line |
| periph_oe | input | LINES | Peripheral output enable per line |
| pad_in | input | LINES | Level seen on each pad |
| pad_out | output | LINES | Value driven to each pad |
| pad_oe | output | LINES | Pad driver enable per line |

## Verification
The assertions take for granted that at most one bus write completes per cycle, and that paddr and pwdata stay stable through the access phase. The stimulus holds these steady: the bus is driven one full transfer at a time, a fixed delay after each rising edge. The pad level is modelled as the driven value when pad_oe is high and as an external level otherwise. That level and the peripheral inputs change only between transfers. This keeps every pin-word expectation in the bench tied to a known two-cycle window after each change.

// File: rtl/gpio_odrv_pkg.sv
package gpio_odrv_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_SET     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CLR     = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_WEN_ON  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_WEN_OFF = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_WEN_ST  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_OD_ON   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_OD_OFF  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_OD_ST   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_PIN     = 8'h24;
endpackage

// File: rtl/gpio_sc_mask.sv
// Per-bit mask register with separate set and clear strobes.
module gpio_sc_mask #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         on_we,
  input  logic         off_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (on_we)  q_d = q | wdata;
    if (off_we) q_d = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (on_we || off_we) q <= q_d;
  end
endmodule

// File: rtl/gpio_out_data.sv
// Output data register: set, clear and permission-masked direct load.
module gpio_out_data #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         dat_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wen,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         upd;

  assign upd = set_we | clr_we | dat_we;

  always_comb begin
    q_d = q;
    if (set_we) q_d = q | wdata;
    if (clr_we) q_d = q & ~wdata;
    if (dat_we) q_d = (q & ~wen) | (wdata & wen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (upd) q <= q_d;
  end
endmodule

// File: rtl/gpio_line_drv.sv
// Per-line source selection and push-pull / open-drain drive.
module gpio_line_drv #(
  parameter int W = 32
) (
  input  logic [W-1:0] odata,
  input  logic [W-1:0] out_en,
  input  logic [W-1:0] od,
  input  logic [W-1:0] periph_sel,
  input  logic [W-1:0] periph_out,
  input  logic [W-1:0] periph_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic src_d;
    logic src_oe;
    always_comb begin
      src_d  = periph_sel[i] ? periph_out[i] : odata[i];
      src_oe = periph_sel[i] ? periph_oe[i]  : out_en[i];
      if (od[i]) begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = src_oe & ~src_d;
      end else begin
        pad_out[i] = src_d;
        pad_oe[i]  = src_oe;
      end
    end
  end
endmodule

// File: rtl/gpio_pin_sample.sv
// Two-flop synchronizer; the second flop is the pin word, held while clock is gated.
module gpio_pin_sample #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) meta_q <= '0;
    else        meta_q <= pad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin <= '0;
    else if (clk_en) pin <= meta_q;
  end
endmodule

// File: rtl/gpio_odrv_bank.sv
module gpio_odrv_bank
  import gpio_odrv_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [LINES-1:0]  pwdata,
  output logic [LINES-1:0]  prdata,
  input  logic              clk_en,
  input  logic [LINES-1:0]  out_en,
  input  logic [LINES-1:0]  periph_sel,
  input  logic [LINES-1:0]  periph_out,
  input  logic [LINES-1:0]  periph_oe,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);
  localparam int W = LINES;

  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic         wr_acc;
  logic [W-1:0] odata;
  logic [W-1:0] wen;
  logic [W-1:0] od;
  logic [W-1:0] pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_acc = psel & penable & pwrite;

  gpio_out_data #(.W(W)) u_odata (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_we (wr_acc && paddr == OFS_SET),
    .clr_we (wr_acc && paddr == OFS_CLR),
    .dat_we (wr_acc && paddr == OFS_DATA),
    .wdata  (pwdata),
    .wen    (wen),
    .q      (odata)
  );

  gpio_sc_mask #(.W(W)) u_wen (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .on_we  (wr_acc && paddr == OFS_WEN_ON),
    .off_we (wr_acc && paddr == OFS_WEN_OFF),
    .wdata  (pwdata),
    .q      (wen)
  );

  gpio_sc_mask #(.W(W)) u_od (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .on_we  (wr_acc && paddr == OFS_OD_ON),
    .off_we (wr_acc && paddr == OFS_OD_OFF),
    .wdata  (pwdata),
    .q      (od)
  );

  gpio_line_drv #(.W(W)) u_drv (
    .odata      (odata),
    .out_en     (out_en),
    .od         (od),
    .periph_sel (periph_sel),
    .periph_out (periph_out),
    .periph_oe  (periph_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  gpio_pin_sample #(.W(W)) u_pin (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clk_en (clk_en),
    .pad_in (pad_in),
    .pin    (pin)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        OFS_DATA:   prdata = odata;
        OFS_WEN_ST: prdata = wen;
        OFS_OD_ST:  prdata = od;
        OFS_PIN:    prdata = pin;
        default:    prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_odrv_chk.sv
module gpio_odrv_chk
  import gpio_odrv_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_acc,
  input logic [ADDR_W-1:0] paddr,
  input logic [W-1:0]      pwdata,
  input logic [W-1:0]      odata,
  input logic [W-1:0]      wen,
  input logic [W-1:0]      od,
  input logic [W-1:0]      periph_sel,
  input logic [W-1:0]      pad_oe,
  input logic              clk_en,
  input logic [W-1:0]      pin
);
  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_acc && paddr == OFS_SET) |=> ((odata & $past(pwdata)) == $past(pwdata))); // R1
  AST_ODATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_acc |=> $stable(odata)); // R1
  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_acc && paddr == OFS_CLR) |=> ((odata & $past(pwdata)) == '0)); // R2
  AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_acc && paddr == OFS_DATA) |=> (((odata ^ $past(odata)) & ~$past(wen)) == '0)); // R3
  AST_WEN_ON_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_acc && paddr == OFS_WEN_ON) |=> ((wen & $past(pwdata)) == $past(pwdata))); // R4
  AST_OD_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_acc && paddr == OFS_OD_OFF) |=> ((od & $past(pwdata)) == '0)); // R5
  AST_OD_DRIVES_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((od & ~periph_sel & pad_oe & odata) == '0)); // R6
  AST_PIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clk_en |=> $stable(pin)); // R9
endmodule

bind gpio_odrv_bank gpio_odrv_chk #(.W(LINES)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_acc     (wr_acc),
  .paddr      (paddr),
  .pwdata     (pwdata),
  .odata      (odata),
  .wen        (wen),
  .od         (od),
  .periph_sel (periph_sel),
  .pad_oe     (pad_oe),
  .clk_en     (clk_en),
  .pin        (pin)
);

// File: tb/gpio_odrv_bank_tb.sv
module gpio_odrv_bank_tb;
  import gpio_odrv_pkg::*;
  localparam int L = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          psel, penable, pwrite;
  logic [7:0]    paddr;
  logic [L-1:0]  pwdata, prdata;
  logic          clk_en;
  logic [L-1:0]  out_en, periph_sel, periph_out, periph_oe;
  logic [L-1:0]  pad_in, pad_out, pad_oe, ext;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [L-1:0] exp;
    logic [L-1:0] mask;
    string        tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_odrv_bank #(.LINES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .clk_en(clk_en),
    .out_en(out_en), .periph_sel(periph_sel), .periph_out(periph_out),
    .periph_oe(periph_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Monitor: pops one expected item per completed read access.
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: read with no expected item, actual %h", prdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if ((prdata & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h (mask %h)", it.tag,
                   prdata & it.mask, it.exp & it.mask, it.mask);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [L-1:0] d);
    @(posedge clk); #1; psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [L-1:0] e,
                           input logic [L-1:0] m, input string tag);
    item_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1; psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    clk_en = 1; periph_sel = '0; periph_out = '0; periph_oe = '0;
    out_en = 32'hFFEF_FFFF;          // line 20 is a pure input
    ext    = 32'hFFFF_FFFE;          // line 0 pulled low externally
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    repeat (4) @(posedge clk);

    // Reset state
    @(negedge clk); chk("R10 pad_out after reset", pad_out, '0);
    rd_expect(OFS_DATA,   '0, '1, "R10 data after reset");
    rd_expect(OFS_WEN_ST, '0, '1, "R4 permission mask after reset");
    rd_expect(OFS_OD_ST,  '0, '1, "R5 open-drain mask after reset");

    // Set and clear
    apb_wr(OFS_SET, 32'h0000_00F0);
    rd_expect(OFS_DATA, 32'h0000_00F0, '1, "R1 set");
    apb_wr(OFS_SET, 32'h0000_0003);
    rd_expect(OFS_DATA, 32'h0000_00F3, '1, "R1 zero bits unchanged");
    apb_wr(OFS_CLR, 32'h0000_0030);
    rd_expect(OFS_DATA, 32'h0000_00C3, '1, "R2 clear");

    // Masked direct write
    apb_wr(OFS_DATA, 32'hFFFF_FFFF);
    rd_expect(OFS_DATA, 32'h0000_00C3, '1, "R3 write with empty mask");
    apb_wr(OFS_WEN_ON, 32'h0000_FF00);
    rd_expect(OFS_WEN_ST, 32'h0000_FF00, '1, "R4 mask enable");
    apb_wr(OFS_DATA, 32'h1234_5678);
    rd_expect(OFS_DATA, 32'h0000_56C3, '1, "R3 masked write");
    apb_wr(OFS_WEN_OFF, 32'h0000_0F00);
    rd_expect(OFS_WEN_ST, 32'h0000_F000, '1, "R4 mask disable");

    // Open-drain drive (data = 0x56C3: bits 0,1,6 = 1, bit 2 = 0)
    apb_wr(OFS_OD_ON, 32'h0000_0003);
    rd_expect(OFS_OD_ST, 32'h0000_0003, '1, "R5 open-drain enable");
    @(negedge clk);
    chk("R6 open-drain 1 releases", pad_oe[1:0], 2'b00);
    chk("R6 push-pull 1 drives high", {pad_oe[6], pad_out[6]}, 2'b11);
    chk("R6 push-pull 0 drives low", {pad_oe[2], pad_out[2]}, 2'b10);
    rd_expect(OFS_PIN, 32'h0, 32'h1, "R8 released line reads external level");
    apb_wr(OFS_CLR, 32'h0000_0001);
    @(negedge clk);
    chk("R6 open-drain 0 drives low", {pad_oe[0], pad_out[0]}, 2'b10);
    apb_wr(OFS_OD_OFF, 32'h0000_0002);
    rd_expect(OFS_OD_ST, 32'h0000_0001, '1, "R5 open-drain disable");
    @(negedge clk);
    chk("R6 line back to push-pull", {pad_oe[1], pad_out[1]}, 2'b11);

    // Peripheral-driven lines
    apb_wr(OFS_OD_ON, 32'h0000_0010);
    @(posedge clk); #1;
    periph_sel = 32'h0000_0030; periph_out = 32'h0000_0030; periph_oe = 32'h0000_0030;
    @(negedge clk);
    chk("R7 peripheral open-drain 1 releases", pad_oe[4], 1'b0);
    chk("R7 peripheral push-pull drives 1", {pad_oe[5], pad_out[5]}, 2'b11);
    @(posedge clk); #1; periph_out = 32'h0000_0020;
    @(negedge clk);
    chk("R7 peripheral open-drain 0 drives low", {pad_oe[4], pad_out[4]}, 2'b10);
    rd_expect(OFS_PIN, 32'h0000_0020, 32'h0000_0030, "R8 peripheral-driven levels");

    // Pin readback latency on line 8 (push-pull, currently 0)
    apb_wr(OFS_SET, 32'h0000_0100);
    psel = 1; pwrite = 0; paddr = OFS_PIN;
    @(negedge clk); chk("R8 latency cycle 0", prdata[8], 1'b0);
    @(posedge clk); #1;
    @(negedge clk); chk("R8 latency cycle 1", prdata[8], 1'b0);
    @(posedge clk); #1;
    @(negedge clk); chk("R8 latency cycle 2", prdata[8], 1'b1);
    @(posedge clk); #1; psel = 0;

    // Pure input line 20 and clock gating
    rd_expect(OFS_PIN, 32'h0010_0000, 32'h0010_0000, "R8 input line high");
    @(posedge clk); #1; clk_en = 0; ext[20] = 1'b0;
    repeat (5) @(posedge clk);
    rd_expect(OFS_PIN, 32'h0010_0000, 32'h0010_0000, "R9 frozen while gated");
    @(posedge clk); #1; clk_en = 1;
    repeat (3) @(posedge clk);
    rd_expect(OFS_PIN, 32'h0, 32'h0010_0000, "R9 follows after ungating");

    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    finish_run();
  end
endmodule